// File: doc/BRIEF.md
# Address-Generation Interlock Stall Unit

This block sits at the decode stage of an in-order integer pipeline. The pipeline runs decode, address generation, two cache cycles, one execute cycle and a writeback cycle. Each cycle the decoder presents one instruction descriptor. The descriptor carries a class code, an optional destination register and up to two address-source registers (base and index). The unit decides whether that instruction may issue in the current cycle. If it may not, the unit raises `stall` and the decoder holds the instruction. It issues (`issue` high) in the first cycle in which every constraint is met.

There are two kinds of constraint. The first is the address-generation interlock. A consumer that forms an address from a register written by a recent producer must issue a minimum number of cycles after that producer. The distance depends on the producer's class, because loads and load-address instructions have bypass paths back to address generation. The second is execute-stage occupancy. Calls and the multi-cycle classes hold the single execute stage for several cycles, and the next instruction must wait for it to be released. A short history of issued instructions is shifted every cycle, and bubbles are shifted in too, so idle cycles count toward every distance.

Top module: `agi_stall_unit`

## Requirements
- R1: After synchronous reset, `stall` and `issue` are low while no instruction is presented. The first valid instruction issues in the cycle in which it is presented.
- R2: `issue` is high exactly when `in_valid` is high and `stall` is low. `stall` is never high while `in_valid` is low. A held instruction issues in its first legal cycle.
- R3: A producer of class reg-int (0), agen-int (1), call (6) or multi-cycle (7) with a written destination must issue at least 5 cycles before an address consumer that reads that register.
- R4: A load (2) producer must issue at least 3 cycles before a dependent address consumer.
- R5: A load-address producer, either the base+displacement form (4) or the relative form (5), must issue at least 2 cycles before a dependent address consumer.
- R6: Only the classes agen-int (1), load (2), store (3), load-address (4) and call (6) are checked as address consumers. Reg-int (0), relative load-address (5) and multi-cycle (7) never stall for an address dependence.
- R7: A source field holding register 0 never raises a hazard, and neither does a source field whose valid bit is low. A producer whose destination is register 0 or not valid creates no hazard. A store (3) creates no hazard.
- R8: After issue, the execute stage is held for 5 cycles by a call (6). Class 7 holds it for 2 cycles with `in_o_sel`=0 and 3 cycles with `in_o_sel`=1. Every other class holds it for 1 cycle. The next instruction issues no earlier than that many cycles later.
- R9: Cycles with no issue age the history like issued instructions do, so idle cycles count toward every distance.
- R10: The base and index fields are both compared against the tracked destinations, and a match on either raises a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A descriptor is presented this cycle |
| in_class | input | 3 | Instruction class code (see R3 to R8) |
| in_o_sel | input | 1 | For class 7: 0 selects 2-cycle, 1 selects 3-cycle occupancy |
| in_dst | input | 4 | Destination register |
| in_dst_vld | input | 1 | Destination register is written |
| in_base | input | 4 | Base address register |
| in_base_vld | input | 1 | Base field is used |
| in_idx | input | 4 | Index address register |
| in_idx_vld | input | 1 | Index field is used |
| stall | output | 1 | Presented instruction must be held |
| issue | output | 1 | Presented instruction issues this cycle |

## Verification
The bench builds the unit with its default parameters: distances of 5, 3 and 2, occupancies of 5, 2 and 3, and a five-slot history. With these values the longest distance just fills the history. A producer that is four slots deep still stalls a consumer, and one that is five slots deep has just aged out. Register numbers in the random stream are drawn from a small set, so matches and register-0 sources are frequent, and overlapping occupancy and address constraints are exercised together.

// File: rtl/agi_pkg.sv
package agi_pkg;

    localparam int AGI_RW = 4;

    typedef enum logic [2:0] {
        CLS_REG   = 3'd0,
        CLS_AGEN  = 3'd1,
        CLS_LOAD  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_LADDR = 3'd4,
        CLS_LREL  = 3'd5,
        CLS_CALL  = 3'd6,
        CLS_MULTI = 3'd7
    } icls_e;

    typedef struct packed {
        logic              live;
        icls_e             cls;
        logic [AGI_RW-1:0] dst;
    } hent_t;

    function automatic logic is_addr_consumer(icls_e c);
        return (c == CLS_AGEN) || (c == CLS_LOAD) || (c == CLS_STORE) ||
               (c == CLS_LADDR) || (c == CLS_CALL);
    endfunction

    function automatic int producer_gap(icls_e c, int d_ord, int d_load, int d_laddr);
        case (c)
            CLS_LOAD:           return d_load;
            CLS_LADDR, CLS_LREL: return d_laddr;
            CLS_STORE:          return 0;
            default:            return d_ord;
        endcase
    endfunction

    function automatic int exec_hold(icls_e c, logic osel, int o_call, int o_two, int o_three);
        case (c)
            CLS_CALL:  return o_call;
            CLS_MULTI: return osel ? o_three : o_two;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/agi_hist.sv
module agi_hist
    import agi_pkg::*;
#(
    parameter int DEPTH   = 5,
    parameter int D_ORD   = 5,
    parameter int D_LOAD  = 3,
    parameter int D_LADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  icls_e             push_cls,
    input  logic [AGI_RW-1:0] push_dst,
    input  logic              push_dst_vld,
    input  logic              consumer,
    input  logic [AGI_RW-1:0] src0,
    input  logic              src0_vld,
    input  logic [AGI_RW-1:0] src1,
    input  logic              src1_vld,
    output logic              hazard
);
    localparam logic [AGI_RW-1:0] REG_NONE = '0;

    hent_t            slot [DEPTH];
    logic [DEPTH-1:0] hit;
    logic             s0_use;
    logic             s1_use;

    assign s0_use = src0_vld && (src0 != REG_NONE);
    assign s1_use = src1_vld && (src1 != REG_NONE);

    // Slot k holds the instruction issued k+1 cycles ago (or a bubble).
    always_ff @(posedge clk) begin
        if (rst) begin
            slot[0] <= '0;
        end else begin
            slot[0].live <= push && push_dst_vld && (push_dst != REG_NONE) &&
                            (producer_gap(push_cls, D_ORD, D_LOAD, D_LADDR) > 0);
            slot[0].cls  <= push_cls;
            slot[0].dst  <= push_dst;
        end
    end

    generate
        for (genvar k = 1; k < DEPTH; k++) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) slot[k] <= '0;
                else     slot[k] <= slot[k-1];
            end
        end
        for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
            always_comb begin
                hit[k] = slot[k].live &&
                         ((s0_use && (src0 == slot[k].dst)) ||
                          (s1_use && (src1 == slot[k].dst))) &&
                         ((k + 1) < producer_gap(slot[k].cls, D_ORD, D_LOAD, D_LADDR));
            end
        end
    endgenerate

    assign hazard = consumer && (|hit);

    // R7
    reg0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (src0 == REG_NONE && !src1_vld) |-> !hazard);

    generate
        if (DEPTH > 1) begin : g_age_chk
            // R9
            age_shift_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (slot[1] == $past(slot[0])));
        end
    endgenerate

endmodule

// File: rtl/agi_exec.sv
module agi_exec
    import agi_pkg::*;
#(
    parameter int OCC_CALL  = 5,
    parameter int OCC_TWO   = 2,
    parameter int OCC_THREE = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  icls_e take_cls,
    input  logic  take_osel,
    output logic  busy
);
    localparam int MAX_A  = (OCC_CALL > OCC_TWO) ? OCC_CALL : OCC_TWO;
    localparam int MAX_OCC = (MAX_A > OCC_THREE) ? MAX_A : OCC_THREE;
    localparam int CW     = $clog2(MAX_OCC + 1);

    logic [CW-1:0] remain;
    logic [CW-1:0] load_val;

    assign load_val = CW'(exec_hold(take_cls, take_osel, OCC_CALL, OCC_TWO, OCC_THREE) - 1);

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (take)          remain <= load_val;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(remain) < MAX_OCC);

endmodule

// File: rtl/agi_stall_unit.sv
module agi_stall_unit
    import agi_pkg::*;
#(
    parameter int HIST_DEPTH = 5,
    parameter int D_ORD      = 5,
    parameter int D_LOAD     = 3,
    parameter int D_LADDR    = 2,
    parameter int OCC_CALL   = 5,
    parameter int OCC_TWO    = 2,
    parameter int OCC_THREE  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          in_class,
    input  logic                in_o_sel,
    input  logic [AGI_RW-1:0]   in_dst,
    input  logic                in_dst_vld,
    input  logic [AGI_RW-1:0]   in_base,
    input  logic                in_base_vld,
    input  logic [AGI_RW-1:0]   in_idx,
    input  logic                in_idx_vld,
    output logic                stall,
    output logic                issue
);
    icls_e cls;
    logic  consumer;
    logic  addr_haz;
    logic  ex_busy;

    assign cls      = icls_e'(in_class);
    assign consumer = in_valid && is_addr_consumer(cls);

    agi_hist #(
        .DEPTH   (HIST_DEPTH),
        .D_ORD   (D_ORD),
        .D_LOAD  (D_LOAD),
        .D_LADDR (D_LADDR)
    ) u_hist (
        .clk          (clk),
        .rst          (rst),
        .push         (issue),
        .push_cls     (cls),
        .push_dst     (in_dst),
        .push_dst_vld (in_dst_vld),
        .consumer     (consumer),
        .src0         (in_base),
        .src0_vld     (in_base_vld),
        .src1         (in_idx),
        .src1_vld     (in_idx_vld),
        .hazard       (addr_haz)
    );

    agi_exec #(
        .OCC_CALL  (OCC_CALL),
        .OCC_TWO   (OCC_TWO),
        .OCC_THREE (OCC_THREE)
    ) u_exec (
        .clk       (clk),
        .rst       (rst),
        .take      (issue),
        .take_cls  (cls),
        .take_osel (in_o_sel),
        .busy      (ex_busy)
    );

    assign stall = in_valid && (addr_haz || ex_busy);
    assign issue = in_valid && !stall;

    // R8
    call_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_CALL) |=> !issue);

    // R4
    load_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_LOAD && in_dst_vld && in_dst != '0) |=>
        !(issue && is_addr_consumer(cls) && in_base_vld && in_base == $past(in_dst)));

    // R3
    ord_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_REG && in_dst_vld && in_dst != '0) |=>
        !(issue && is_addr_consumer(cls) && in_idx_vld && in_idx == $past(in_dst)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!stall && !issue));

endmodule

// File: tb/agi_stall_unit_bench.sv
module agi_stall_unit_bench;
    localparam int TCLK = 10;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_o_sel, in_dst_vld, in_base_vld, in_idx_vld;
    logic [2:0] in_class;
    logic [3:0] in_dst, in_base, in_idx;
    logic stall, issue;

    // pending drive values, applied at the falling edge
    logic d_valid, d_osel, d_dv, d_bv, d_iv;
    logic [2:0] d_cls;
    logic [3:0] d_dst, d_base, d_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { int c; int cls; int dst; bit dv; } rec_t;
    rec_t hist_q[$];
    int last_issue = -100;
    int last_occ = 1;
    bit exp_issue;

    always #(TCLK/2) clk = ~clk;

    agi_stall_unit u_agi_stall_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_o_sel(in_o_sel), .in_dst(in_dst), .in_dst_vld(in_dst_vld),
        .in_base(in_base), .in_base_vld(in_base_vld), .in_idx(in_idx),
        .in_idx_vld(in_idx_vld), .stall(stall), .issue(issue)
    );

    function automatic int m_need(int c);
        if (c == 2) return 3;
        if (c == 3) return 0;
        if (c == 4 || c == 5) return 2;
        return 5;
    endfunction

    function automatic int m_occ(int c, bit o);
        if (c == 6) return 5;
        if (c == 7) return o ? 3 : 2;
        return 1;
    endfunction

    function automatic bit m_cons(int c);
        return c == 1 || c == 2 || c == 3 || c == 4 || c == 6;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        bit haz, busy, es;
        @(negedge clk);
        in_valid = d_valid; in_class = d_cls; in_o_sel = d_osel;
        in_dst = d_dst; in_dst_vld = d_dv; in_base = d_base; in_base_vld = d_bv;
        in_idx = d_idx; in_idx_vld = d_iv;
        #1;
        haz = 0;
        if (d_valid && m_cons(d_cls)) begin
            foreach (hist_q[i]) begin
                if (hist_q[i].dv && hist_q[i].dst != 0 &&
                    (cyc - hist_q[i].c) < m_need(hist_q[i].cls) &&
                    ((d_bv && d_base != 0 && d_base == hist_q[i].dst) ||
                     (d_iv && d_idx != 0 && d_idx == hist_q[i].dst)))
                    haz = 1;
            end
        end
        busy = (cyc - last_issue) < last_occ;
        es = d_valid && (haz || busy);
        exp_issue = d_valid && !es;
        check("R2 stall model", int'(stall), int'(es));
        check("R2 issue model", int'(issue), int'(exp_issue));
        if (exp_issue) begin
            hist_q.push_back('{c: cyc, cls: int'(d_cls), dst: int'(d_dst), dv: d_dv});
            if (hist_q.size() > 8) void'(hist_q.pop_front());
            last_issue = cyc;
            last_occ = m_occ(d_cls, d_osel);
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        d_valid = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send(input int c, input bit o, input int dst, input bit dv,
                        input int b, input bit bv, input int x, input bit xv,
                        output int stalls);
        d_valid = 1; d_cls = 3'(c); d_osel = o; d_dst = 4'(dst); d_dv = dv;
        d_base = 4'(b); d_bv = bv; d_idx = 4'(x); d_iv = xv;
        stalls = 0;
        for (int g = 0; g < 50; g++) begin
            step();
            if (exp_issue) break;
            stalls++;
        end
    endtask

    task automatic pair(input string tag, input int pc, input bit po, input int pd,
                        input int gap, input int cc, input int b, input bit bv,
                        input int x, input bit xv, input int exp_st);
        int s;
        idle(6);
        send(pc, po, pd, 1, 0, 0, 0, 0, s);
        if (gap > 0) idle(gap);
        send(cc, 0, 0, 0, b, bv, x, xv, s);
        check(tag, s, exp_st);
    endtask

    initial begin
        int s;
        d_valid = 0; d_cls = 0; d_osel = 0; d_dst = 0; d_dv = 0;
        d_base = 0; d_bv = 0; d_idx = 0; d_iv = 0;
        in_valid = 0; in_class = 0; in_o_sel = 0; in_dst = 0; in_dst_vld = 0;
        in_base = 0; in_base_vld = 0; in_idx = 0; in_idx_vld = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        check("R1 stall after reset", int'(stall), 0);
        check("R1 issue after reset", int'(issue), 0);
        send(0, 0, 9, 1, 0, 0, 0, 0, s);
        check("R1 first issue stalls", s, 0);

        pair("R3 reg to agen base", 0, 0, 1, 0, 1, 1, 1, 0, 0, 4);
        pair("R10 load to store index", 2, 0, 2, 0, 3, 0, 0, 2, 1, 2);
        pair("R4 load to load base", 2, 0, 2, 0, 2, 2, 1, 0, 0, 2);
        pair("R5 la to load", 4, 0, 3, 0, 2, 3, 1, 0, 0, 1);
        pair("R5 relative la to call", 5, 0, 4, 0, 6, 4, 1, 0, 0, 1);
        pair("R6 reg consumer not checked", 0, 0, 5, 0, 0, 5, 1, 0, 0, 0);
        pair("R6 relative la consumer not checked", 0, 0, 5, 0, 5, 5, 1, 5, 1, 0);
        pair("R7 register 0 source", 0, 0, 0, 0, 1, 0, 1, 0, 1, 0);
        pair("R7 store produces nothing", 3, 0, 6, 0, 2, 6, 1, 0, 0, 0);
        pair("R7 invalid base field", 0, 0, 6, 0, 1, 6, 0, 0, 0, 0);
        pair("R8 call occupancy", 6, 0, 0, 0, 0, 0, 0, 0, 0, 4);
        pair("R8 o3 occupancy", 7, 1, 0, 0, 0, 0, 0, 0, 0, 2);
        pair("R8 o2 occupancy", 7, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        pair("R3 call producer to agen", 6, 0, 8, 0, 1, 8, 1, 0, 0, 4);
        pair("R9 idle cycles age history", 0, 0, 7, 2, 1, 7, 1, 0, 0, 2);
        pair("R9 distance fully aged", 0, 0, 7, 4, 1, 0, 0, 7, 1, 0);

        idle(6);
        for (int n = 0; n < 3000; n++) begin
            int c;
            c = $urandom_range(0, 7);
            send(c, 1'($urandom_range(0, 1)), $urandom_range(0, 5), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 5), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 5), 1'($urandom_range(0, 1)), s);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule